// File: doc/BRIEF.md
# Supervisory Reset and Watchdog Timer

This block drives the reset line of a processor. A supply monitor outside the block supplies a single synchronous bit that is high when the supply is above its trip level. A timebase supplies a one-cycle strobe once per millisecond. The block holds reset active whenever the supply bit is low, and keeps it active for a fixed hold time after the supply recovers. The hold time is 200 ms nominal and is set by a parameter as a number of ticks.

The watchdog input shares its pin with the serial chip-select. Software restarts the watchdog by pulling that pin from high to low. The block resynchronizes the pin and watches only for falling edges. If no falling edge arrives within the selected timeout, the block asserts reset for the same hold time and then starts the watchdog again from zero. A two-bit field from a status register selects the timeout, and one code of that field turns the watchdog off. A volatile flag records whether the latest reset came from the watchdog or from low supply. A parameter sets the polarity of the reset output.

Top module: `supv_reset_wdog`

## Requirements
- R1: Reset is active from the first clock edge at which the supply bit is sampled low, including at power-up, and it stays active for as long as the supply bit is low.
- R2: Once the supply bit is high, reset stays active until HOLD_TICKS timebase strobes have been counted. It is released in the cycle after the strobe that completes the count.
- R3: A low sample of the supply bit during the hold restarts the hold, so a full HOLD_TICKS strobes are needed again after recovery.
- R4: Only a high-to-low transition of the watchdog pin restarts the watchdog count. The pin passes through two synchronizer flops before edge detection. A rising edge, or a pin held steady high or low, does not restart the count.
- R5: While the watchdog is enabled and reset is inactive, reset is asserted at the timebase strobe that brings the number of strobes since the last restart up to the selected timeout.
- R6: The select field encodes the timeout as follows: 00 = 7×HOLD_TICKS (1.4 s), 01 = 3×HOLD_TICKS (600 ms), 10 = 1×HOLD_TICKS (200 ms). Code 11 disables the watchdog.
- R7: A reset caused by the watchdog lasts HOLD_TICKS strobes. After it ends, the watchdog count restarts from zero.
- R8: The cause flag goes to 1 when the watchdog causes a reset and goes to 0 when the supply bit is low. Between those events it holds its value.
- R9: With ACTIVE_LOW=1, the output is 0 when reset is active. With ACTIVE_LOW=0, the output is 1 when reset is active.
- R10: The watchdog count is held at zero while any reset is active, so every release grants a full timeout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous power-on clear, active low |
| supplyOk | input | 1 | Synchronous supply-above-trip indicator |
| wdiPin | input | 1 | Shared chip-select / watchdog pin, asynchronous |
| wdSel | input | 2 | Watchdog timeout select from the status register |
| msTick | input | 1 | One-cycle timebase strobe, nominally 1 ms |
| rstOut | output | 1 | Processor reset, polarity set by ACTIVE_LOW |
| wdCause | output | 1 | 1 = last reset caused by the watchdog, 0 = by low supply |

## Verification
The bench builds the block with HOLD_TICKS=4. This shrinks the hold to four strobes and the longest timeout to 28 strobes, so the last strobe before each timeout and the strobe that reaches it can both be checked for every select code in a short run. Two instances, one with ACTIVE_LOW=1 and one with ACTIVE_LOW=0, receive the same stimulus, so both output polarities are compared on every check.

// File: rtl/supv_pkg.sv
package supv_pkg;

  // Strobes from the control FSM to the counter datapath
  typedef struct packed {
    logic holdClr;
    logic holdStep;
    logic wdClr;
    logic wdStep;
  } supvStrobe_t;

  typedef enum logic [1:0] {
    ST_LOW  = 2'd0,
    ST_HOLD = 2'd1,
    ST_RUN  = 2'd2
  } supvState_t;

  localparam logic [1:0] WD_SEL_OFF = 2'b11;

  // Timeout as a multiple of the hold period; 0 means disabled
  function automatic logic [2:0] wdMultiple(input logic [1:0] sel);
    case (sel)
      2'b00:   wdMultiple = 3'd7;
      2'b01:   wdMultiple = 3'd3;
      2'b10:   wdMultiple = 3'd1;
      default: wdMultiple = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/supv_datapath.sv
module supv_datapath
  import supv_pkg::*;
#(
  parameter int HOLD_TICKS = 200
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wdiPin,
  input  logic [1:0]  wdSel,
  input  logic        msTick,
  input  supvStrobe_t strobe,
  output logic        holdDone,
  output logic        wdExpire
);

  localparam int MAX_TICKS = 7 * HOLD_TICKS;
  localparam int CW        = $clog2(MAX_TICKS + 1);
  localparam int HW        = $clog2(HOLD_TICKS + 1);
  localparam int SYNC_LEN  = 2;

  // Two-flop synchronizer followed by an edge register
  logic [SYNC_LEN-1:0] syncQ;
  logic                prevQ;
  logic                kick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '1;
      prevQ <= 1'b1;
    end else begin
      syncQ <= {syncQ[SYNC_LEN-2:0], wdiPin};
      prevQ <= syncQ[SYNC_LEN-1];
    end
  end

  assign kick = prevQ & ~syncQ[SYNC_LEN-1];

  // Hold counter
  logic [HW-1:0] holdCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          holdCnt <= '0;
    else if (strobe.holdClr)            holdCnt <= '0;
    else if (strobe.holdStep && msTick) holdCnt <= holdCnt + HW'(1);
  end

  assign holdDone = strobe.holdStep && msTick && (holdCnt == HW'(HOLD_TICKS - 1));

  // Timeout decode
  logic [CW-1:0] wdLimit;
  logic          wdEnabled;

  always_comb begin
    case (wdMultiple(wdSel))
      3'd7:    wdLimit = CW'(7 * HOLD_TICKS);
      3'd3:    wdLimit = CW'(3 * HOLD_TICKS);
      3'd1:    wdLimit = CW'(HOLD_TICKS);
      default: wdLimit = '0;
    endcase
  end

  assign wdEnabled = (wdSel != WD_SEL_OFF);

  // Watchdog counter
  logic [CW-1:0] wdCnt;
  logic          wdAtLimit;

  assign wdAtLimit = (wdCnt >= (wdLimit - CW'(1)));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            wdCnt <= '0;
    else if (strobe.wdClr || kick)        wdCnt <= '0;
    else if (strobe.wdStep && wdEnabled && msTick &&
             (wdCnt != CW'(MAX_TICKS)))   wdCnt <= wdCnt + CW'(1);
  end

  assign wdExpire = strobe.wdStep && wdEnabled && msTick && !kick && wdAtLimit;

endmodule

// File: rtl/supv_ctrl.sv
module supv_ctrl
  import supv_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        supplyOk,
  input  logic        holdDone,
  input  logic        wdExpire,
  output supvStrobe_t strobe,
  output logic        rstActive,
  output logic        wdCause
);

  supvState_t state, stateNext;

  always_comb begin
    stateNext = state;
    if (!supplyOk) begin
      stateNext = ST_LOW;
    end else begin
      case (state)
        ST_LOW:  stateNext = ST_HOLD;
        ST_HOLD: if (holdDone) stateNext = ST_RUN;
        ST_RUN:  if (wdExpire) stateNext = ST_HOLD;
        default: stateNext = ST_LOW;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_LOW;
    else       state <= stateNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                             wdCause <= 1'b0;
    else if (!supplyOk)                    wdCause <= 1'b0;
    else if (state == ST_RUN && wdExpire)  wdCause <= 1'b1;
  end

  always_comb begin
    strobe.holdClr  = (state != ST_HOLD);
    strobe.holdStep = (state == ST_HOLD);
    strobe.wdClr    = (state != ST_RUN);
    strobe.wdStep   = (state == ST_RUN);
  end

  assign rstActive = (state != ST_RUN);

endmodule

// File: rtl/supv_reset_wdog.sv
module supv_reset_wdog
  import supv_pkg::*;
#(
  parameter int HOLD_TICKS = 200,
  parameter bit ACTIVE_LOW = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       supplyOk,
  input  logic       wdiPin,
  input  logic [1:0] wdSel,
  input  logic       msTick,
  output logic       rstOut,
  output logic       wdCause
);

  supvStrobe_t strobe;
  logic        holdDone;
  logic        wdExpire;
  logic        rstActive;

  supv_datapath #(.HOLD_TICKS(HOLD_TICKS)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .wdiPin   (wdiPin),
    .wdSel    (wdSel),
    .msTick   (msTick),
    .strobe   (strobe),
    .holdDone (holdDone),
    .wdExpire (wdExpire)
  );

  supv_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .supplyOk  (supplyOk),
    .holdDone  (holdDone),
    .wdExpire  (wdExpire),
    .strobe    (strobe),
    .rstActive (rstActive),
    .wdCause   (wdCause)
  );

  generate
    if (ACTIVE_LOW) begin : g_outLow
      assign rstOut = ~rstActive;
    end else begin : g_outHigh
      assign rstOut = rstActive;
    end
  endgenerate

endmodule

// File: rtl/supv_reset_wdog_chk.sv
module supv_reset_wdog_chk #(
  parameter bit ACTIVE_LOW = 1'b1
) (
  input logic       clk,
  input logic       rstN,
  input logic       supplyOk,
  input logic [1:0] wdSel,
  input logic       msTick,
  input logic       rstOut,
  input logic       wdCause
);

  logic act;
  assign act = ACTIVE_LOW ? ~rstOut : rstOut;

  // R1: a low supply sample forces reset from the next cycle
  p_low_supply_r1: assert property (@(posedge clk) disable iff (!rstN)
    !supplyOk |=> act);

  // R2: release happens only after a strobe with the supply good
  p_release_on_tick_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(act) |-> ($past(msTick) && $past(supplyOk)));

  // R5: a watchdog reset starts only on a strobe
  p_wd_on_tick_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(act) && $past(supplyOk)) |-> $past(msTick));

  // R6: disabled code never starts a reset while the supply is good
  p_disabled_r6: assert property (@(posedge clk) disable iff (!rstN)
    (supplyOk && $past(supplyOk) && $past(wdSel) == 2'b11) |-> !$rose(act));

  // R8: cause flag rises together with a reset
  p_cause_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wdCause) |-> act);

  // R8: cause flag clears only on a low supply
  p_cause_clr_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wdCause) |-> !$past(supplyOk));

endmodule

bind supv_reset_wdog supv_reset_wdog_chk #(.ACTIVE_LOW(ACTIVE_LOW)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .supplyOk (supplyOk),
  .wdSel    (wdSel),
  .msTick   (msTick),
  .rstOut   (rstOut),
  .wdCause  (wdCause)
);

// File: tb/supv_reset_wdog_tb_top.sv
`timescale 1ns/1ps
module supv_reset_wdog_tb_top;

  localparam int HOLD = 4;

  typedef struct packed {
    logic [1:0] sel;
    logic [7:0] nTicks;
    logic       expAct;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{sel: 2'b10, nTicks: 8'd3,  expAct: 1'b0},
    '{sel: 2'b10, nTicks: 8'd4,  expAct: 1'b1},
    '{sel: 2'b01, nTicks: 8'd11, expAct: 1'b0},
    '{sel: 2'b01, nTicks: 8'd12, expAct: 1'b1},
    '{sel: 2'b00, nTicks: 8'd27, expAct: 1'b0},
    '{sel: 2'b00, nTicks: 8'd28, expAct: 1'b1},
    '{sel: 2'b11, nTicks: 8'd40, expAct: 1'b0},
    '{sel: 2'b11, nTicks: 8'd60, expAct: 1'b0}
  };

  logic       clk = 1'b0;
  logic       rstN;
  logic       supplyOk;
  logic       wdiPin;
  logic [1:0] wdSel;
  logic       msTick;
  logic       rstOutL, rstOutH, causeL, causeH;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  supv_reset_wdog #(.HOLD_TICKS(HOLD), .ACTIVE_LOW(1'b1)) dut_i (
    .clk(clk), .rstN(rstN), .supplyOk(supplyOk), .wdiPin(wdiPin),
    .wdSel(wdSel), .msTick(msTick), .rstOut(rstOutL), .wdCause(causeL));

  supv_reset_wdog #(.HOLD_TICKS(HOLD), .ACTIVE_LOW(1'b0)) dutHi_i (
    .clk(clk), .rstN(rstN), .supplyOk(supplyOk), .wdiPin(wdiPin),
    .wdSel(wdSel), .msTick(msTick), .rstOut(rstOutH), .wdCause(causeH));

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick(input int n);
    repeat (n) begin
      @(negedge clk) msTick = 1'b1;
      @(negedge clk) msTick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic kick();
    @(negedge clk) wdiPin = 1'b0;
    idle(4);
    wdiPin = 1'b1;
    idle(4);
  endtask

  task automatic recover();
    @(negedge clk) supplyOk = 1'b0;
    idle(2);
    supplyOk = 1'b1;
    idle(2);
    tick(HOLD);
    idle(2);
  endtask

  // Checks reset state on both polarities and the cause flag
  task automatic checkState(input string req, input bit expAct, input bit expCause);
    nChecks++;
    if (rstOutL !== ~expAct || rstOutH !== expAct || causeL !== expCause || causeH !== expCause) begin
      nFails++;
      $display("FAIL %s: rstOutL=%b rstOutH=%b cause=%b/%b expected rstOutL=%b rstOutH=%b cause=%b",
               req, rstOutL, rstOutH, causeL, causeH, ~expAct, expAct, expCause);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  initial begin
    rstN = 1'b0; supplyOk = 1'b0; wdiPin = 1'b1; wdSel = 2'b10; msTick = 1'b0;
    idle(3);
    rstN = 1'b1;
    idle(3);
    checkState("R1 power-up low supply", 1'b1, 1'b0);
    supplyOk = 1'b1;
    idle(2);
    checkState("R2 hold start", 1'b1, 1'b0);
    tick(HOLD - 1);
    checkState("R2 one strobe short", 1'b1, 1'b0);
    tick(1);
    checkState("R2 release / R9 polarity", 1'b0, 1'b0);

    // R3: glitch during hold restarts it
    supplyOk = 1'b0; idle(2);
    checkState("R1 brownout", 1'b1, 1'b0);
    supplyOk = 1'b1; idle(1);
    tick(2);
    supplyOk = 1'b0; idle(1);
    supplyOk = 1'b1; idle(1);
    tick(HOLD - 1);
    checkState("R3 hold restarted", 1'b1, 1'b0);
    tick(1);
    checkState("R3 release after full hold", 1'b0, 1'b0);

    // R4: regular kicks keep reset off
    repeat (5) begin tick(HOLD - 1); kick(); end
    checkState("R4 kicked watchdog", 1'b0, 1'b0);
    // Pin held high: missed kick
    tick(HOLD - 1);
    checkState("R5 before timeout", 1'b0, 1'b0);
    tick(1);
    checkState("R4 held high expires / R8 cause set", 1'b1, 1'b1);
    tick(HOLD - 1);
    checkState("R7 watchdog hold length", 1'b1, 1'b1);
    tick(1);
    checkState("R7 watchdog reset release", 1'b0, 1'b1);
    tick(HOLD - 1);
    checkState("R7 count restarted from zero", 1'b0, 1'b1);
    // Falling edge kicks, rising edge does not
    wdiPin = 1'b0; idle(4);
    tick(2);
    wdiPin = 1'b1; idle(4);
    tick(1);
    checkState("R4 rising edge ignored, not yet timed out", 1'b0, 1'b1);
    tick(1);
    checkState("R4 rising edge ignored, expires", 1'b1, 1'b1);
    idle(1);
    supplyOk = 1'b0; idle(2);
    checkState("R8 cause cleared by low supply", 1'b1, 1'b0);
    supplyOk = 1'b1; idle(1);
    tick(HOLD);
    idle(1);

    // R10: count cleared during supply reset
    tick(HOLD - 1);
    recover();
    tick(HOLD - 1);
    checkState("R10 count cleared during reset", 1'b0, 1'b0);

    // R6 / R5: table of select codes
    for (int i = 0; i < NVEC; i++) begin
      wdSel = VECS[i].sel;
      recover();
      tick(int'(VECS[i].nTicks));
      idle(2);
      checkState($sformatf("R6 sel=%b ticks=%0d", VECS[i].sel, VECS[i].nTicks),
                 VECS[i].expAct, VECS[i].expAct);
    end

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      summary();
      $finish;
    end
  end

endmodule